// File: doc/BRIEF.md
# Tag-check system register bank

This block holds the system registers that control memory tagging in a 64-bit processor. It has four tag-fault status registers, one for each exception level: slot 0 records faults from user code and is managed from EL1, and slots 1 to 3 belong to EL1, EL2 and EL3. It also has a seed register for random tag generation, a tag-control register, a constant granule-identification register, and the tag-check-override bit of the processor state.

The pipeline issues at most one decoded register access per cycle. An access carries the 16-bit register encoding, a write flag, a flag for the move-immediate form, the write data, the current exception level and the trap controls. One cycle later the block returns the read data and a 2-bit result code. The result code either accepts the access or sends it to undefined-instruction handling, to EL2 or to EL3. The override bit is also driven out continuously so that the tag-check datapath can use it.

A feature-level input selects how much of the bank exists. With full tagging the whole bank exists. With only the user-level tag instructions, the bank shrinks to an override register that reads as zero and ignores writes. With no tagging, every access is undefined.

Top module: `tagreg_bank`

## Requirements
- R1: After reset the six read/write registers hold zero, the override bit is 0 and `rsp_vld` is low.
- R2: `rsp_vld` is high in exactly the cycle after `acc_vld` was high. `rsp_data` is zero whenever `rsp_trap` is non-zero and for every write.
- R3: The encoding layout is {op0[15:14], op1[13:11], CRn[10:7], CRm[6:3], op2[2:0]}. Fault slots 0 to 3 are at (3,0,5,6,1), (3,0,5,6,0), (3,4,5,6,0) and (3,6,5,6,0). The seed register is at (3,0,1,0,5) and the control register at (3,0,1,0,6). Each of these six registers stores all 64 bits of an accepted write and returns them on a read.
- R4: Result codes are 0 for accepted, 1 for undefined, 2 for a trap to EL2 and 3 for a trap to EL3. An unknown encoding gives 1. An access below the register's level also gives 1: the EL1 registers need level 1 or higher, fault slot 2 needs level 2 or higher, and fault slot 3 needs level 3. The level check comes before every other check.
- R5: Fault slots 0 to 2, the seed register and the control register give code 2 when the current level is below 2, `has_el2` is high and `hyp_tag_en` is low.
- R6: If R5 does not trap, the same registers give code 3 when the current level is below 3, `has_el3` is high and `mon_tag_en` is low. Fault slot 3 is exempt from both tag-enable traps.
- R7: The granule register (3,1,0,0,4) reads 6 in bits [3:0] and 0 in all other bits. A write to it gives code 1. It gives code 2 when the current level is below 2, `has_el2` is high and `hyp_tid5` is high.
- R8: The override register (3,3,4,2,7) can be accessed from EL0 and is never trapped by the tag enables. A read returns the override bit at bit 25 and zeros elsewhere. A write copies bit 25 of `acc_wdata` into the override bit.
- R9: With `acc_imm` high, CRm bit 0 (`acc_enc[3]`) is written into the override bit. This works from any level and gives code 0.
- R10: With `feat_lvl`=1, the override register reads zero and gives code 0. Register writes and immediate writes to it change nothing. Every other encoding gives code 1.
- R11: With `feat_lvl`=0, every access, including the immediate form, gives code 1.
- R12: The host alias (3,5,5,6,0) reaches fault slot 1 only when `host_redir` is high and the level is at least 2; otherwise it gives code 1. When `host_redir` is high at level 2, the slot-1 encoding reaches fault slot 2.
- R13: An access that gives a non-zero result code leaves every register and the override bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Access strobe |
| acc_enc | input | 16 | Register encoding {op0,op1,CRn,CRm,op2} |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_imm | input | 1 | Move-immediate form targeting the override bit |
| acc_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| has_el2 | input | 1 | EL2 is implemented |
| has_el3 | input | 1 | EL3 is implemented |
| hyp_tag_en | input | 1 | Hypervisor allocation-tag enable |
| mon_tag_en | input | 1 | Secure-monitor allocation-tag enable |
| hyp_tid5 | input | 1 | Hypervisor trap control for the granule register |
| host_redir | input | 1 | Host mode redirects EL1 accesses to EL2 |
| feat_lvl | input | 2 | 0 = no tagging, 1 = user-level instructions only, 2 = full |
| rsp_vld | output | 1 | Response valid |
| rsp_data | output | 64 | Read data |
| rsp_trap | output | 2 | Result code |
| tco_o | output | 1 | Current override bit |

## Verification
The assertions check the response timing, zero data on every trapped response, and the stability of the override bit on every cycle. The override bit must hold when there is no access, under a trap, and in the reduced feature mode. The assertions also check that the no-tagging mode returns undefined and that immediate writes land in the override bit. Only the bench scenarios can show the ordering of the layered traps, the per-level privilege rules, the alias and host redirection, and the full 64-bit contents of the fault, seed and control registers. These need a model of the stored state, which the bench keeps and compares against the read data.

// File: rtl/tagreg_bank.sv
module tagreg_bank #(
  parameter int DW = 64,
  parameter logic [3:0] GRANULE_BS = 4'd6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic [15:0]   acc_enc,
  input  logic          acc_wr,
  input  logic          acc_imm,
  input  logic [DW-1:0] acc_wdata,
  input  logic [1:0]    cur_el,
  input  logic          has_el2,
  input  logic          has_el3,
  input  logic          hyp_tag_en,
  input  logic          mon_tag_en,
  input  logic          hyp_tid5,
  input  logic          host_redir,
  input  logic [1:0]    feat_lvl,
  output logic          rsp_vld,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    rsp_trap,
  output logic          tco_o
);
  localparam int TCO_BIT = 25;
  localparam int NRW = 6;
  localparam logic [1:0] T_OK = 2'd0, T_UND = 2'd1, T_EL2 = 2'd2, T_EL3 = 2'd3;

  logic [DW-1:0] rw_q [NRW];
  logic          tco_q;

  logic [3:0]    rid;
  logic [1:0]    need_el;
  logic          tag_chk;
  logic [2:0]    slot;
  logic [1:0]    trap;
  logic [DW-1:0] rdata;
  logic          rw_we, tco_we, tco_wv;

  always_comb begin
    case (acc_enc)
      {2'd3, 3'd0, 4'd5, 4'd6, 3'd1}: rid = 4'd0;
      {2'd3, 3'd0, 4'd5, 4'd6, 3'd0}: rid = 4'd1;
      {2'd3, 3'd4, 4'd5, 4'd6, 3'd0}: rid = 4'd2;
      {2'd3, 3'd6, 4'd5, 4'd6, 3'd0}: rid = 4'd3;
      {2'd3, 3'd0, 4'd1, 4'd0, 3'd5}: rid = 4'd4;
      {2'd3, 3'd0, 4'd1, 4'd0, 3'd6}: rid = 4'd5;
      {2'd3, 3'd1, 4'd0, 4'd0, 3'd4}: rid = 4'd6;
      {2'd3, 3'd3, 4'd4, 4'd2, 3'd7}: rid = 4'd7;
      {2'd3, 3'd5, 4'd5, 4'd6, 3'd0}: rid = 4'd8;
      default:                        rid = 4'd15;
    endcase
  end

  always_comb begin
    case (rid)
      4'd2, 4'd8: need_el = 2'd2;
      4'd3:       need_el = 2'd3;
      4'd7:       need_el = 2'd0;
      default:    need_el = 2'd1;
    endcase
  end

  assign tag_chk = (rid <= 4'd2) || rid == 4'd4 || rid == 4'd5 || rid == 4'd8;

  always_comb begin
    case (rid)
      4'd1:    slot = (host_redir && cur_el == 2'd2) ? 3'd2 : 3'd1;
      4'd8:    slot = 3'd1;
      default: slot = rid[2:0];
    endcase
  end

  always_comb begin
    trap = T_OK;
    rdata = '0;
    rw_we = 1'b0;
    tco_we = 1'b0;
    tco_wv = 1'b0;
    if (feat_lvl == 2'd0) begin
      trap = T_UND;
    end else if (acc_imm) begin
      tco_we = (feat_lvl == 2'd2);
      tco_wv = acc_enc[3];
    end else if (feat_lvl == 2'd1) begin
      if (rid != 4'd7) trap = T_UND;
    end else if (rid == 4'd15 || cur_el < need_el || (rid == 4'd8 && !host_redir)) begin
      trap = T_UND;
    end else if (rid == 4'd6 && acc_wr) begin
      trap = T_UND;
    end else if (rid == 4'd6 && cur_el < 2'd2 && has_el2 && hyp_tid5) begin
      trap = T_EL2;
    end else if (tag_chk && cur_el < 2'd2 && has_el2 && !hyp_tag_en) begin
      trap = T_EL2;
    end else if (tag_chk && cur_el < 2'd3 && has_el3 && !mon_tag_en) begin
      trap = T_EL3;
    end else if (rid == 4'd6) begin
      rdata[3:0] = GRANULE_BS;
    end else if (rid == 4'd7) begin
      tco_we = acc_wr;
      tco_wv = acc_wdata[TCO_BIT];
      rdata[TCO_BIT] = tco_q;
    end else begin
      rw_we = acc_wr;
      rdata = rw_q[slot];
    end
  end

  generate
    for (genvar i = 0; i < NRW; i++) begin : g_rw
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rw_q[i] <= '0;
        else if (acc_vld && rw_we && slot == i) rw_q[i] <= acc_wdata;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tco_q    <= 1'b0;
      rsp_vld  <= 1'b0;
      rsp_data <= '0;
      rsp_trap <= T_OK;
    end else begin
      if (acc_vld && tco_we) tco_q <= tco_wv;
      rsp_vld <= acc_vld;
      if (acc_vld) begin
        rsp_trap <= trap;
        rsp_data <= (acc_wr || acc_imm) ? '0 : rdata;
      end
    end
  end

  assign tco_o = tco_q;
endmodule

module tagreg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_vld,
  input logic [15:0] acc_enc,
  input logic        acc_imm,
  input logic [1:0]  feat_lvl,
  input logic        rsp_vld,
  input logic [63:0] rsp_data,
  input logic [1:0]  rsp_trap,
  input logic        tco_o
);
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n) acc_vld |=> rsp_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n) !acc_vld |=> !rsp_vld);
  a_r2_trap_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_trap != 2'd0) |-> rsp_data == 64'd0);
  a_r11_none_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && feat_lvl == 2'd0) |=> rsp_trap == 2'd1);
  a_r10_insn_tco_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && feat_lvl == 2'd1) |=> $stable(tco_o));
  a_r13_trap_keeps_tco: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_trap != 2'd0) |-> $stable(tco_o));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> $stable(tco_o));
  a_r9_imm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_imm && feat_lvl == 2'd2) |=> (tco_o == $past(acc_enc[3]) && rsp_trap == 2'd0));
endmodule

bind tagreg_bank tagreg_bank_chk u_chk (.*);

// File: tb/sim_tagreg_bank.sv
module sim_tagreg_bank;
  logic clk = 0, rst_n = 0;
  logic acc_vld = 0, acc_wr = 0, acc_imm = 0;
  logic [15:0] acc_enc = '0;
  logic [63:0] acc_wdata = '0;
  logic [1:0] cur_el = 0, feat_lvl = 2;
  logic has_el2 = 1, has_el3 = 1, hyp_tag_en = 1, mon_tag_en = 1, hyp_tid5 = 0, host_redir = 0;
  logic rsp_vld, tco_o;
  logic [63:0] rsp_data;
  logic [1:0] rsp_trap;

  int checks = 0, failures = 0;
  logic [63:0] m_rw [6];
  logic m_tco;

  always #2.5 clk = ~clk;

  tagreg_bank u0 (.*);

  function automatic logic [15:0] enc(int o0, int o1, int n, int m, int o2);
    return {o0[1:0], o1[2:0], n[3:0], m[3:0], o2[2:0]};
  endfunction

  function automatic logic [15:0] pick_enc(int k);
    case (k)
      0: return enc(3,0,5,6,1);
      1: return enc(3,0,5,6,0);
      2: return enc(3,4,5,6,0);
      3: return enc(3,6,5,6,0);
      4: return enc(3,0,1,0,5);
      5: return enc(3,0,1,0,6);
      6: return enc(3,1,0,0,4);
      7: return enc(3,3,4,2,7);
      8: return enc(3,5,5,6,0);
      default: return enc(3,2,7,1,3);
    endcase
  endfunction

  function automatic int reg_id(logic [15:0] e);
    for (int k = 0; k < 9; k++) if (pick_enc(k) == e) return k;
    return 15;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(string tag, logic [15:0] e, logic wr, logic imm, logic [63:0] wd);
    int id, need, sl;
    logic [1:0] et;
    logic [63:0] ed;
    id = reg_id(e);
    et = 0; ed = 0;
    need = (id == 2 || id == 8) ? 2 : (id == 3) ? 3 : (id == 7) ? 0 : 1;
    sl = (id == 8) ? 1 : (id == 1 && host_redir && cur_el == 2) ? 2 : id;
    if (feat_lvl == 0) et = 1;
    else if (imm) begin if (feat_lvl == 2) m_tco = e[3]; end
    else if (feat_lvl == 1) begin if (id != 7) et = 1; end
    else if (id == 15 || cur_el < need || (id == 8 && !host_redir)) et = 1;
    else if (id == 6 && wr) et = 1;
    else if (id == 6 && cur_el < 2 && has_el2 && hyp_tid5) et = 2;
    else if (id != 3 && id != 6 && id != 7 && cur_el < 2 && has_el2 && !hyp_tag_en) et = 2;
    else if (id != 3 && id != 6 && id != 7 && cur_el < 3 && has_el3 && !mon_tag_en) et = 3;
    else if (id == 6) ed = 64'd6;
    else if (id == 7) begin ed = {38'd0, m_tco, 25'd0}; if (wr) m_tco = wd[25]; end
    else begin ed = m_rw[sl]; if (wr) m_rw[sl] = wd; end
    if (wr || imm) ed = 0;
    acc_enc = e; acc_wr = wr; acc_imm = imm; acc_wdata = wd; acc_vld = 1;
    @(negedge clk);
    acc_vld = 0;
    chk({tag, " vld"}, {63'd0, rsp_vld}, 64'd1);
    chk({tag, " trap"}, {62'd0, rsp_trap}, {62'd0, et});
    chk({tag, " data"}, rsp_data, ed);
    chk({tag, " tco"}, {63'd0, tco_o}, {63'd0, m_tco});
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) m_rw[i] = 0;
    m_tco = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_vld", {63'd0, rsp_vld}, 64'd0);
    chk("R1 tco", {63'd0, tco_o}, 64'd0);
    cur_el = 3;
    for (int k = 0; k < 6; k++) acc("R1 reg zero", pick_enc(k), 0, 0, 0);
    for (int k = 0; k < 6; k++) acc("R3 write", pick_enc(k), 1, 0, {32'hA5A50000 + k, 32'h0F0F1234});
    for (int k = 0; k < 6; k++) acc("R3 readback", pick_enc(k), 0, 0, 0);
    acc("R4 unknown", pick_enc(9), 0, 0, 0);
    cur_el = 0; acc("R4 el0 on el1 reg", pick_enc(4), 0, 0, 0);
    cur_el = 1; acc("R4 el1 on el2 reg", pick_enc(2), 0, 0, 0);
    cur_el = 2; acc("R4 el2 on el3 reg", pick_enc(3), 0, 0, 0);
    cur_el = 1; hyp_tag_en = 0; mon_tag_en = 0;
    acc("R5 hyp trap", pick_enc(5), 1, 0, 64'hDEAD);
    acc("R13 after trap", pick_enc(5), 0, 0, 0);
    hyp_tag_en = 1; acc("R6 mon trap", pick_enc(0), 0, 0, 0);
    cur_el = 3; acc("R6 el3 reg exempt", pick_enc(3), 0, 0, 0);
    cur_el = 2; acc("R6 el2 mon trap", pick_enc(2), 0, 0, 0);
    mon_tag_en = 1;
    cur_el = 1; acc("R7 granule", pick_enc(6), 0, 0, 0);
    acc("R7 granule write", pick_enc(6), 1, 0, 1);
    hyp_tid5 = 1; acc("R7 tid5", pick_enc(6), 0, 0, 0);
    cur_el = 2; acc("R7 tid5 el2", pick_enc(6), 0, 0, 0); hyp_tid5 = 0;
    cur_el = 0; hyp_tag_en = 0; mon_tag_en = 0;
    acc("R8 tco write", pick_enc(7), 1, 0, 64'h0000_0000_0200_0000);
    acc("R8 tco read", pick_enc(7), 0, 0, 0);
    acc("R9 imm clear", enc(3,3,4,2,7), 0, 1, 0);
    acc("R9 imm set", enc(3,3,4,3,7), 0, 1, 0);
    hyp_tag_en = 1; mon_tag_en = 1;
    feat_lvl = 1;
    acc("R10 tco ro", pick_enc(7), 0, 0, 0);
    acc("R10 tco wi", pick_enc(7), 1, 0, 0);
    acc("R10 imm wi", enc(3,3,4,2,7), 0, 1, 0);
    acc("R10 other undef", pick_enc(4), 0, 0, 0);
    feat_lvl = 0;
    acc("R11 none", pick_enc(7), 0, 0, 0);
    acc("R11 none imm", enc(3,3,4,2,7), 0, 1, 0);
    feat_lvl = 2; cur_el = 2;
    acc("R12 alias no host", pick_enc(8), 0, 0, 0);
    host_redir = 1;
    acc("R12 alias", pick_enc(8), 0, 0, 0);
    acc("R12 redirect write", pick_enc(1), 1, 0, 64'h1122334455667788);
    acc("R12 el2 reg", pick_enc(2), 0, 0, 0);
    host_redir = 0;
    for (int i = 0; i < 800; i++) begin
      logic [31:0] r;
      r = $urandom;
      cur_el = r[1:0]; has_el2 = r[2]; has_el3 = r[3];
      hyp_tag_en = r[4] | r[5]; mon_tag_en = r[6] | r[7];
      hyp_tid5 = r[8] & r[9]; host_redir = r[10];
      feat_lvl = (r[13:11] == 0) ? 2'd0 : (r[13:11] == 1) ? 2'd1 : 2'd2;
      acc("R3-R13 random", pick_enc($urandom_range(0, 9)) ^ {12'd0, r[14] & r[15], 3'd0},
          r[16], r[17] & r[18] & r[19], {$urandom, $urandom});
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule